// File: doc/BRIEF.md
# Low-Power Mode Controller With State Retention

This block selects the chip's power mode and drives the enables that follow from it. It has one enable each for the radio domain, the analog domain, the PLL, the crystal oscillator, the digital core supply and the low-power clock that feeds the wake sequencer. There are four modes: active, doze, deep-sleep and power-down. Software running in active mode asks for a lower mode with a one-cycle request and a two-bit mode code. The block then walks the ordered sequence for that mode.

Deep-sleep is the only mode with handshakes. On entry the block asks an always-on retention store to save the core state, and it removes core power only after the store acknowledges. On exit it restores core power first and waits for a power-good indication. It then asks the store to reload the state, and it returns to active only after that acknowledge.

Three wake sources bring the chip out of doze or deep-sleep: a sequencer timer, an external interrupt and a host resume. A wake that arrives while the save is still in progress is held, and it takes effect as soon as the sleep state is reached. Power-down turns everything off, and only an external enable brings the chip out of it.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode output is active (code 00), all six enables are high, both handshake requests are low and ret_valid is low.
- R2: In active, a sleep_req with sleep_mode 01 enters doze, 10 starts deep-sleep entry and 11 enters power-down, each at the next edge. Code 00 leaves the block in active. mode_o uses the same codes.
- R3: In doze, radio_en, analog_en, pll_en and xtal_en are low, while core_pwr_en and lpclk_en stay high.
- R4: In doze, any of the three wake inputs returns the block to active at the next edge.
- R5: Deep-sleep entry raises save_req with core power and main clocks on, and with radio and analog off. The core supply is removed only at the edge after save_ack, and ret_valid is set at that same edge.
- R6: A wake that arrives during the save phase is latched. It starts the exit one edge after the sleep state is reached, with no further wake needed.
- R7: Deep-sleep exit first raises core_pwr_en, pll_en and xtal_en. It holds there until core_pgood, then raises restore_req until restore_ack. It then returns to active and clears ret_valid.
- R8: In the deep-sleep state without a pending wake, the block stays asleep with only lpclk_en high. Each of timer_wake, ext_irq and host_resume starts the exit.
- R9: In power-down, all six enables are low. The wake inputs are ignored and only ext_en returns the block to active.
- R10: In active, the wake inputs and the three acknowledge inputs have no effect. They are not remembered for a later deep-sleep either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle request to leave active |
| sleep_mode | input | 2 | Target mode code (01 doze, 10 deep-sleep, 11 power-down) |
| timer_wake | input | 1 | Sequencer timer expiry wake |
| ext_irq | input | 1 | External interrupt wake |
| host_resume | input | 1 | Host resume wake |
| ext_en | input | 1 | External enable, sole exit from power-down |
| save_ack | input | 1 | Retention store has saved the core state |
| core_pgood | input | 1 | Core supply is good after power-up |
| restore_ack | input | 1 | Retention store has reloaded the core state |
| mode_o | output | 2 | Current mode code |
| radio_en | output | 1 | Radio domain enable |
| analog_en | output | 1 | Analog domain enable |
| pll_en | output | 1 | PLL enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| core_pwr_en | output | 1 | Digital core supply enable |
| lpclk_en | output | 1 | Low-power clock enable to the sequencer |
| save_req | output | 1 | Save request to the retention store |
| restore_req | output | 1 | Restore request to the retention store |
| ret_valid | output | 1 | Retention store holds a valid saved state |

## Verification
The assertions check ordering and mode rules on every cycle:
- the core supply falls in deep-sleep only after a save acknowledge;
- a restore request rises only with core power on and power-good seen;
- doze and power-down always show their enable patterns;
- power-down is left only through ext_en;
- the two handshake requests never overlap.

Some behaviour shows up only in the bench's sequences. These are the latching of a wake during the save phase, the fact that no wake seen in active is kept, each individual wake source, and the full exit timing cycle by cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W   = 2;
    localparam int NUM_WAKE = 3;
    localparam int STATE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_ACT  = 2'd0,
        MODE_DOZE = 2'd1,
        MODE_DEEP = 2'd2,
        MODE_PDN  = 2'd3
    } lpm_mode_e;

    typedef enum logic [STATE_W-1:0] {
        S_ACT   = 3'd0,
        S_DOZE  = 3'd1,
        S_SAVE  = 3'd2,
        S_SLEEP = 3'd3,
        S_PWRUP = 3'd4,
        S_REST  = 3'd5,
        S_PDN   = 3'd6
    } lpm_state_e;

    typedef struct packed {
        logic radio;
        logic analog;
        logic pll;
        logic xtal;
        logic core;
        logic lpclk;
    } lpm_en_t;

    function automatic lpm_mode_e state_to_mode(lpm_state_e s);
        case (s)
            S_ACT:   return MODE_ACT;
            S_DOZE:  return MODE_DOZE;
            S_PDN:   return MODE_PDN;
            default: return MODE_DEEP;
        endcase
    endfunction

    function automatic lpm_en_t state_to_en(lpm_state_e s);
        lpm_en_t e;
        e = '0;
        case (s)
            S_ACT:   e = '{radio: 1'b1, analog: 1'b1, pll: 1'b1, xtal: 1'b1, core: 1'b1, lpclk: 1'b1};
            S_DOZE:  e = '{radio: 1'b0, analog: 1'b0, pll: 1'b0, xtal: 1'b0, core: 1'b1, lpclk: 1'b1};
            S_SAVE,
            S_PWRUP,
            S_REST:  e = '{radio: 1'b0, analog: 1'b0, pll: 1'b1, xtal: 1'b1, core: 1'b1, lpclk: 1'b1};
            S_SLEEP: e = '{radio: 1'b0, analog: 1'b0, pll: 1'b0, xtal: 1'b0, core: 1'b0, lpclk: 1'b1};
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic wake_armed(lpm_state_e s);
        return (s != S_ACT) && (s != S_PDN);
    endfunction

endpackage

// File: rtl/lpm_wake_latch.sv
module lpm_wake_latch #(
    parameter int NW = lpm_pkg::NUM_WAKE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] wake_i,
    input  logic          arm,
    input  logic          clr,
    output logic          wake_any
);
    logic pend_q;
    logic hit;

    assign hit = |wake_i;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_q <= 1'b0;
        end else if (arm && hit) begin
            pend_q <= 1'b1;
        end
    end

    assign wake_any = arm && (pend_q || hit);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  lpm_mode_e  sleep_mode,
    input  logic       wake_any,
    input  logic       ext_en,
    input  logic       save_ack,
    input  logic       core_pgood,
    input  logic       restore_ack,
    output lpm_state_e state,
    output logic       ret_valid
);
    lpm_state_e nxt;
    logic       rv_set;
    logic       rv_clr;

    always_comb begin
        nxt    = state;
        rv_set = 1'b0;
        rv_clr = 1'b0;
        case (state)
            S_ACT: begin
                if (sleep_req) begin
                    case (sleep_mode)
                        MODE_DOZE: nxt = S_DOZE;
                        MODE_DEEP: nxt = S_SAVE;
                        MODE_PDN:  nxt = S_PDN;
                        default:   nxt = S_ACT;
                    endcase
                end
            end
            S_DOZE:  if (wake_any) nxt = S_ACT;
            S_SAVE: begin
                if (save_ack) begin
                    nxt    = S_SLEEP;
                    rv_set = 1'b1;
                end
            end
            S_SLEEP: if (wake_any) nxt = S_PWRUP;
            S_PWRUP: if (core_pgood) nxt = S_REST;
            S_REST: begin
                if (restore_ack) begin
                    nxt    = S_ACT;
                    rv_clr = 1'b1;
                end
            end
            S_PDN:   if (ext_en) nxt = S_ACT;
            default: nxt = S_ACT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_ACT;
            ret_valid <= 1'b0;
        end else begin
            state <= nxt;
            if (rv_set) begin
                ret_valid <= 1'b1;
            end else if (rv_clr) begin
                ret_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
    import lpm_pkg::*;
(
    input  lpm_state_e state,
    output lpm_en_t    en,
    output lpm_mode_e  mode,
    output logic       save_req,
    output logic       restore_req
);
    assign en          = state_to_en(state);
    assign mode        = state_to_mode(state);
    assign save_req    = (state == S_SAVE);
    assign restore_req = (state == S_REST);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] sleep_mode,
    input  logic              timer_wake,
    input  logic              ext_irq,
    input  logic              host_resume,
    input  logic              ext_en,
    input  logic              save_ack,
    input  logic              core_pgood,
    input  logic              restore_ack,
    output logic [MODE_W-1:0] mode_o,
    output logic              radio_en,
    output logic              analog_en,
    output logic              pll_en,
    output logic              xtal_en,
    output logic              core_pwr_en,
    output logic              lpclk_en,
    output logic              save_req,
    output logic              restore_req,
    output logic              ret_valid
);
    lpm_state_e          state;
    lpm_en_t             en;
    lpm_mode_e           mode;
    logic                wake_any;
    logic [NUM_WAKE-1:0] wake_vec;

    assign wake_vec = {host_resume, ext_irq, timer_wake};

    lpm_wake_latch #(.NW(NUM_WAKE)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .wake_i   (wake_vec),
        .arm      (wake_armed(state)),
        .clr      (state == S_ACT),
        .wake_any (wake_any)
    );

    lpm_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_req   (sleep_req),
        .sleep_mode  (lpm_mode_e'(sleep_mode)),
        .wake_any    (wake_any),
        .ext_en      (ext_en),
        .save_ack    (save_ack),
        .core_pgood  (core_pgood),
        .restore_ack (restore_ack),
        .state       (state),
        .ret_valid   (ret_valid)
    );

    lpm_out_dec u_dec (
        .state       (state),
        .en          (en),
        .mode        (mode),
        .save_req    (save_req),
        .restore_req (restore_req)
    );

    assign mode_o      = mode;
    assign radio_en    = en.radio;
    assign analog_en   = en.analog;
    assign pll_en      = en.pll;
    assign xtal_en     = en.xtal;
    assign core_pwr_en = en.core;
    assign lpclk_en    = en.lpclk;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ext_en,
    input logic       save_ack,
    input logic       core_pgood,
    input logic [1:0] mode_o,
    input logic       radio_en,
    input logic       analog_en,
    input logic       pll_en,
    input logic       xtal_en,
    input logic       core_pwr_en,
    input logic       lpclk_en,
    input logic       save_req,
    input logic       restore_req,
    input logic       ret_valid
);
    // R5: core supply drops in deep-sleep only after the save acknowledge
    a_r5_save_before_off: assert property (@(posedge clk) disable iff (rst)
        ($fell(core_pwr_en) && mode_o == 2'd2) |-> $past(save_ack));

    // R5: ret_valid rises only on a save acknowledge
    a_r5_valid_on_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ret_valid) |-> $past(save_ack));

    // R7: restore is requested only with core power on, after power-good
    a_r7_restore_after_pgood: assert property (@(posedge clk) disable iff (rst)
        $rose(restore_req) |-> (core_pwr_en && $past(core_pgood)));

    // R7: the save and restore handshakes never overlap
    a_r7_handshake_excl: assert property (@(posedge clk) disable iff (rst)
        !(save_req && restore_req));

    // R3: enable pattern in doze
    a_r3_doze_pattern: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1) |-> (!radio_en && !analog_en && !pll_en && !xtal_en && core_pwr_en && lpclk_en));

    // R9: everything off in power-down
    a_r9_pdown_all_off: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd3) |-> (!radio_en && !analog_en && !pll_en && !xtal_en && !core_pwr_en && !lpclk_en));

    // R9: power-down is left only through ext_en
    a_r9_pdown_exit_ext: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd3 && !ext_en) |=> (mode_o == 2'd3));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (.*);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [1:0] sleep_mode = 2'd0;
    logic       timer_wake = 1'b0, ext_irq = 1'b0, host_resume = 1'b0;
    logic       ext_en = 1'b0, save_ack = 1'b0, core_pgood = 1'b0, restore_ack = 1'b0;
    logic [1:0] mode_o;
    logic       radio_en, analog_en, pll_en, xtal_en, core_pwr_en, lpclk_en;
    logic       save_req, restore_req, ret_valid;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lpm_ctrl u_lpm_ctrl (.*);

    // stim {sleep_req, sleep_mode[1:0], timer, irq, host, ext_en, save_ack, pgood, restore_ack}
    // exp  {mode[1:0], radio, analog, pll, xtal, core, lpclk, save_req, restore_req, ret_valid}
    localparam int NV = 25;
    localparam logic [20:0] VEC [NV] = '{
        21'b0_00_000_0_000_00_111111_000, // R10 idle active
        21'b1_01_000_0_000_01_000011_000, // R2 R3 enter doze
        21'b0_00_000_0_000_01_000011_000, // R3 doze holds
        21'b0_00_010_0_000_00_111111_000, // R4 irq wakes doze
        21'b1_10_000_0_000_10_001111_100, // R2 R5 save phase
        21'b0_00_001_0_000_10_001111_100, // R6 host wake during save, latched
        21'b0_00_000_0_100_10_000001_001, // R5 save_ack, core off, valid set
        21'b0_00_000_0_000_10_001111_001, // R6 latched wake starts exit
        21'b0_00_000_0_000_10_001111_001, // R7 wait for pgood
        21'b0_00_000_0_010_10_001111_011, // R7 restore request
        21'b0_00_000_0_001_00_111111_000, // R7 restore_ack, active, valid cleared
        21'b0_00_010_0_111_00_111111_000, // R10 wake and acks ignored in active
        21'b1_10_000_0_000_10_001111_100, // R5 deep-sleep again
        21'b0_00_000_0_100_10_000001_001, // R5 asleep
        21'b0_00_000_0_000_10_000001_001, // R8 R10 no stale wake, stays asleep
        21'b0_00_100_0_000_10_001111_001, // R8 timer wake
        21'b0_00_000_0_010_10_001111_011, // R7
        21'b0_00_000_0_001_00_111111_000, // R7
        21'b1_11_000_0_000_11_000000_000, // R2 R9 power-down
        21'b0_00_111_0_000_11_000000_000, // R9 wakes ignored
        21'b0_00_000_1_000_00_111111_000, // R9 ext_en exits
        21'b1_00_000_0_000_00_111111_000, // R2 code 00 stays active
        21'b1_10_000_0_000_10_001111_100, // R5
        21'b0_00_000_0_100_10_000001_001, // R5
        21'b0_00_010_0_000_10_001111_001  // R8 irq wake from deep-sleep
    };

    function automatic logic [10:0] outs();
        return {mode_o, radio_en, analog_en, pll_en, xtal_en, core_pwr_en, lpclk_en,
                save_req, restore_req, ret_valid};
    endfunction

    task automatic apply(input logic [9:0] s);
        {sleep_req, sleep_mode, timer_wake, ext_irq, host_resume, ext_en,
         save_ack, core_pgood, restore_ack} = s;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [10:0] exp);
        tests++;
        if (outs() !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, outs(), exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        check("R1 reset state", 11'b00_111111_000);
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][20:11]);
            step();
            check($sformatf("vector %0d", i), VEC[i][10:0]);
        end
        apply('0);
        step();
        check("R7 exit waits for pgood", 11'b10_001111_001);
        // R1: reset mid-exit returns to active with ret_valid cleared
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 reset during exit", 11'b00_111111_000);
        // R5: the core stays on while save_ack is absent
        apply(10'b1_10_000_0_000);
        step();
        apply('0);
        step();
        step();
        check("R5 holds save without ack", 11'b10_001111_100);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule